// File: doc/BRIEF.md
# Glitch-free binary timer prescaler

This block divides a module clock by a power of two for a free-running main timer. On each clock it may raise a single-cycle count-enable pulse, and a main counter advances by one on every pulse. A small select input `n` picks how many divide-by-two stages sit in front of the main counter, so the pulse rate is the clock rate divided by 2^n.

The select input may change at any time. The new value is not applied at once. It is captured only on a clock where every stage of the internal prescale counter is zero. Every pulse interval therefore matches either the old ratio or the new one, and no shortened or stretched period occurs. A global run input freezes the whole timer. While it is low, the prescale phase and the main count stay where they are.

Top module: `timer_prescaler`

## Requirements
- R1: While reset is high, `cnt_tick` is low. After reset, `main_count` is 0, the prescale phase restarts from zero and the select value present applies at once, so the first pulse comes after exactly 2^n enabled cycles.
- R2: `div_sel` is a plain binary number n in 0..7. Once it has been applied, pulses are exactly 2^n enabled cycles apart (1, 2, 4 ... 128).
- R3: A new select value is captured only on a clock where the 7-bit prescale counter is zero. Every interval between pulses equals the old factor or the new factor.
- R4: When the select changes in the middle of a prescale cycle, pulses continue at the old factor until the prescale counter returns to zero.
- R5: While `run_en` is low, `cnt_tick` stays low, `main_count` holds and the prescale phase holds. A pulse interval counts only enabled cycles.
- R6: `main_count` rises by exactly one on the clock edge after each pulse, and only then.
- R7: `main_count` wraps from 0xFFFF to 0x0000.
- R8: With n = 0, `cnt_tick` is high on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Global timer enable |
| div_sel | input | 3 | Requested number of divide-by-two stages |
| cnt_tick | output | 1 | One-cycle count-enable pulse |
| main_count | output | 16 | Free-running main counter value |

## Verification
The bench uses the default parameters: three select bits, which give a seven-stage prescale counter, and a 16-bit main counter. With these values the full ratio range of 1 to 128 can be tested in a few hundred cycles per ratio, and a ratio switch can be timed against a prescale cycle of known phase after reset. The main counter can also be run to its wrap at divide-by-1 in about 65,536 cycles.

// File: rtl/timer_prescaler_pkg.sv
package timer_prescaler_pkg;

    // Mask with the low n bits set (n is at most 31).
    function automatic int unsigned low_ones(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/pscl_sel_hold.sv
module pscl_sel_hold #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             at_zero,
    input  logic [SEL_W-1:0] sel_req,
    output logic [SEL_W-1:0] sel_eff
);
    typedef struct packed {
        logic [SEL_W-1:0] act;
    } hold_t;

    hold_t st_d, st_q;

    // Select is taken over only at the all-zero boundary of the stages.
    always_comb begin
        sel_eff = at_zero ? sel_req : st_q.act;
        st_d    = st_q;
        st_d.act = sel_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: away from the boundary the applied ratio cannot move
    a_r3_hold_off_boundary: assert property (@(posedge clk) disable iff (rst)
        !at_zero |=> ($past(sel_eff) == st_q.act));
endmodule

// File: rtl/pscl_stage_ctr.sv
module pscl_stage_ctr #(
    parameter int SEL_W = 3,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [SEL_W-1:0] sel_eff,
    output logic             at_zero,
    output logic             tick
);
    import timer_prescaler_pkg::*;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } stage_t;

    stage_t           st_d, st_q;
    logic [PRE_W-1:0] lo_mask;

    always_comb begin
        lo_mask = PRE_W'(low_ones(32'(sel_eff)));
        at_zero = (st_q.pre == '0);
        tick    = !rst && run_en && (&(st_q.pre | ~lo_mask));
        st_d    = st_q;
        if (run_en) st_d.pre = st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R5: a stopped timer keeps its prescale phase
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(st_q.pre));
    // R3: a pulse is never raised on the boundary cycle unless the ratio is 1
    a_r3_zero_tick: assert property (@(posedge clk) disable iff (rst)
        (at_zero && tick) |-> (sel_eff == '0));
endmodule

// File: rtl/pscl_main_ctr.sv
module pscl_main_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } main_t;

    main_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        count = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             cnt_tick,
    output logic [CNT_W-1:0] main_count
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic             at_zero;
    logic [SEL_W-1:0] sel_eff;

    pscl_sel_hold #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .at_zero (at_zero),
        .sel_req (div_sel),
        .sel_eff (sel_eff)
    );

    pscl_stage_ctr #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .sel_eff (sel_eff),
        .at_zero (at_zero),
        .tick    (cnt_tick)
    );

    pscl_main_ctr #(.CNT_W(CNT_W)) u_main (
        .clk   (clk),
        .rst   (rst),
        .tick  (cnt_tick),
        .count (main_count)
    );

    // R1: counter is clear on the first cycle out of reset
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (main_count == '0));
    // R5: no pulse and no count movement while stopped
    a_r5_no_tick: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !cnt_tick);
    a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_tick |=> $stable(main_count));
    // R6: one step per pulse
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && main_count != '1) |=> (main_count == $past(main_count) + CNT_W'(1)));
    // R7: wrap to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && main_count == '1) |=> (main_count == '0));
    // R8: divide-by-1 pulses on every enabled cycle
    a_r8_every: assert property (@(posedge clk) disable iff (rst)
        (run_en && sel_eff == '0) |-> cnt_tick);
endmodule

// File: tb/test_timer_prescaler.sv
module test_timer_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {select, expected interval in enabled cycles}
    localparam bit [10:0] VEC [NV] = '{
        {3'd5, 8'd32}, {3'd0, 8'd1}, {3'd7, 8'd128}, {3'd2, 8'd4},
        {3'd1, 8'd2},  {3'd6, 8'd64}, {3'd3, 8'd8},  {3'd4, 8'd16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        cnt_tick;
    logic [15:0] main_count;

    timer_prescaler i_timer_prescaler (
        .clk(clk), .rst(rst), .run_en(run_en), .div_sel(div_sel),
        .cnt_tick(cnt_tick), .main_count(main_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_bad = 0;
    int gaps [0:1023];
    int gap_n = 0;
    int since = 0;
    int pause_ticks = 0;
    bit done = 1'b0;

    // Interval monitor, counting enabled cycles only.
    always @(negedge clk) begin
        if (!rst && run_en) begin
            since = since + 1;
            if (cnt_tick) begin
                if (gap_n < 1024) gaps[gap_n] = since;
                gap_n = gap_n + 1;
                since = 0;
            end
        end
        if (!run_en && cnt_tick) pause_ticks = pause_ticks + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        gap_n = 0;
        since = 0;
        pause_ticks = 0;
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst = 1'b1;
        run_en = 1'b0;
        div_sel = s;
        step(3);
        run_en = 1'b1;
        rst = 1'b0;
        clr();
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int m0, idx, fours, others;
        bit hit;

        // R1: reset state and restart of the prescale phase
        rst = 1'b1;
        run_en = 1'b1;
        div_sel = 3'd3;
        step(3);
        @(negedge clk);
        check(cnt_tick == 1'b0, "R1 tick in reset", int'(cnt_tick), 0);
        check(main_count == 16'd0, "R1 count in reset", int'(main_count), 0);
        do_reset(3'd3);
        step(40);
        check(gap_n >= 1 && gaps[0] == 8, "R1 first interval", gaps[0], 8);

        // R2/R6/R8: table of ratios
        for (int i = 0; i < NV; i++) begin
            div_sel = VEC[i][10:8];
            step(300);
            clr();
            m0 = int'(main_count);
            step(600);
            check(gap_n >= 3, "R2 pulses seen", gap_n, 3);
            for (int k = 1; k < gap_n && k < 5; k++)
                check(gaps[k] == int'(VEC[i][7:0]), "R2 interval", gaps[k], int'(VEC[i][7:0]));
            check(int'(16'(main_count - 16'(m0))) == gap_n, "R6 count per pulse",
                  int'(16'(main_count - 16'(m0))), gap_n);
        end

        // R8: divide-by-1 from reset
        do_reset(3'd0);
        step(50);
        @(negedge clk);
        check(cnt_tick == 1'b1, "R8 tick high", int'(cnt_tick), 1);
        check(gap_n == 50, "R8 pulse count", gap_n, 50);

        // R3/R4: switch from 4 to 32 with the prescale counter at 10
        do_reset(3'd2);
        step(10);
        idx = gap_n;
        check(idx == 2, "R4 pulses before change", idx, 2);
        div_sel = 3'd5;
        step(400);
        check(gaps[idx] == 4, "R4 first interval after change", gaps[idx], 4);
        fours = 0;
        others = 0;
        for (int k = idx; k < gap_n; k++) begin
            if (gaps[k] == 4) begin
                if (k == idx + fours) fours++;
                else others++;
            end else if (gaps[k] != 32) others++;
        end
        check(fours == 30, "R4 old-ratio pulses", fours, 30);
        check(others == 0, "R3 partial intervals", others, 0);
        check(gap_n - idx > 32, "R3 new ratio reached", gap_n - idx, 33);

        // R5: pause in the middle of a period
        do_reset(3'd3);
        step(5);
        run_en = 1'b0;
        m0 = int'(main_count);
        step(20);
        check(pause_ticks == 0, "R5 no tick while stopped", pause_ticks, 0);
        check(int'(main_count) == m0, "R5 count holds", int'(main_count), m0);
        run_en = 1'b1;
        step(20);
        check(gap_n >= 2 && gaps[0] == 8, "R5 phase held", gaps[0], 8);
        check(gaps[1] == 8, "R5 interval after resume", gaps[1], 8);

        // R7: wrap of the main counter
        do_reset(3'd0);
        hit = 1'b0;
        for (int c = 0; c < 70000 && !hit; c++) begin
            @(negedge clk);
            if (main_count == 16'hFFFF) hit = 1'b1;
        end
        check(hit, "R7 reached top", int'(hit), 1);
        @(negedge clk);
        check(main_count == 16'h0000, "R7 wrap", int'(main_count), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end
endmodule